// File: doc/BRIEF.md
# Banked Set-Associative Cache Lookup

This block is the read-and-fill lookup stage of a banked, set-associative cache. It splits each request address into four fields: a line offset, a bank index, a set index and a tag. The bank index picks one of several independent banks. The set index picks a set inside that bank. Every way of that set is then compared in parallel, using its valid bit and a bitwise XOR equality test on the tag. On a hit the requested byte is returned. Data is selected in three stages: the line of the hitting way, then the 8-byte word within the line, then the byte within the word.

On a miss the block reports the miss and raises a request to the next memory level. That request carries the line-aligned address. The block then stalls new requests until a fill supplies the whole line. The fill goes into a victim way, which is the lowest-numbered invalid way of the set. When every way of the set is valid, a per-set round-robin pointer chooses the victim instead.

The geometry is parameterised: ways, line size, banks, sets per bank and address width. The defaults are a compact build: 32-bit addresses, 4 ways, 32-byte lines, 4 banks and 4 sets per bank. With these defaults the fields are offset [4:0], bank [6:5], set [8:7] and tag [31:9].

Top module: `banked_cache_lookup`

## Requirements
- R1: After reset, every valid bit is clear. req_ready is 1, resp_valid is 0 and miss_valid is 0, and the first lookup of any address reports a miss.
- R2: With the defaults, the address is decoded as offset [4:0], bank [6:5], set [8:7] and tag [31:9]. Banks are independent: a line filled in one bank does not hit a request that has the same tag and set index but a different bank index.
- R3: A request is accepted on a clock edge where req_valid and req_ready are both 1. On the next cycle the block drives resp_valid=1 and exactly one of resp_hit and resp_miss. On a hit, resp_data is byte k of the stored line, where k = offset. Byte k is fill_data[8k+7:8k]. Offset bits [4:3] pick the 8-byte word and bits [2:0] pick the byte within it.
- R4: On a miss, resp_data is 0. From the same cycle, miss_valid is 1 and miss_addr equals the request address with bits [4:0] cleared. Both hold, and req_ready stays 0, until a fill is taken.
- R5: While miss_valid is 1, a cycle with fill_valid=1 writes fill_data as the line for the missed address, sets that way valid and stores its tag. In the next cycle req_ready is 1 and miss_valid is 0. While no miss is pending, fill_valid is ignored and changes no stored line.
- R6: The victim is the lowest-numbered invalid way of the set. As long as any way of the set is invalid, no valid line of that set is evicted.
- R7: When all ways of a set are valid, the victim is taken from a per-set round-robin pointer. The pointer starts at way 0 after reset and advances by one, wrapping, after each such replacement. Other sets are not affected.
- R8: For any lookup, at most one way of the selected set reports a tag match.
- R9: A request presented while req_ready is 0 is not accepted and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Lookup byte address |
| req_ready | output | 1 | Block can take a request |
| resp_valid | output | 1 | Response for the request accepted in the previous cycle |
| resp_hit | output | 1 | The response is a hit |
| resp_miss | output | 1 | The response is a miss |
| resp_data | output | 8 | Requested byte on a hit, 0 otherwise |
| miss_valid | output | 1 | A line request to the next level is pending |
| miss_addr | output | ADDR_W | Line-aligned address of the pending miss |
| fill_valid | input | 1 | Fill line present |
| fill_data | input | LINE_BYTES*8 | Fill line, byte k in bits [8k+7:8k] |

## Verification
Damage to tag or valid state shows up as a wrong hit/miss flag on the next lookup of the affected line, one cycle after that lookup is accepted. A wrong line or a wrong victim choice stays hidden until a later lookup touches the evicted tag or reads a byte of the overwritten line. For that reason the bench revisits every tag of a full set after each replacement. A fault in the word or byte stage returns a wrong resp_data at once, so lookups sweep offsets across all word and byte positions. A fault in the miss handshake shows within one cycle as a wrong miss_addr, req_ready or miss_valid.

// File: rtl/cbl_pkg.sv
// Package: shared types for the banked cache lookup.
// Assumes: nothing beyond IEEE 1800-2017.
package cbl_pkg;

    // Control state of the lookup unit.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } lkp_state_t;

endpackage

// File: rtl/lkp_victim.sv
// Module: lkp_victim
// Picks the way that a fill will replace in one set. The lowest-numbered
// invalid way wins. When every way is valid, the round-robin pointer is used.
// Assumes: WAYS is a power of two, at least 2.
module lkp_victim #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  vld,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] victim,
    output logic             all_valid
);

    // Scan from the top so the lowest invalid way is the last one written.
    always_comb begin
        all_valid = &vld;
        victim    = rr_ptr;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[w]) victim = WAY_W'(w);
        end
    end

endmodule

// File: rtl/lkp_byte_sel.sv
// Module: lkp_byte_sel
// Second and third stages of data selection. The first stage (picking the
// hitting line) happens in the bank. Here the offset picks a word of the
// line and then a byte of that word.
// Assumes: LINE_BYTES and WORD_BYTES are powers of two, WORD_BYTES >= 2.
module lkp_byte_sel #(
    parameter int LINE_BYTES = 32,
    parameter int WORD_BYTES = 8,
    localparam int WORDS     = LINE_BYTES / WORD_BYTES,
    localparam int WORD_BITS = WORD_BYTES * 8,
    localparam int WIDX_W    = $clog2(WORDS),
    localparam int BIDX_W    = $clog2(WORD_BYTES),
    localparam int OFF_W     = WIDX_W + BIDX_W
) (
    input  logic [LINE_BYTES*8-1:0] line,
    input  logic [OFF_W-1:0]        offset,
    output logic [7:0]              byte_out
);

    logic [WORD_BITS-1:0] words [WORDS];
    logic [7:0]           bytes [WORD_BYTES];
    logic [WORD_BITS-1:0] word_sel;

    for (genvar i = 0; i < WORDS; i++) begin : g_words
        assign words[i] = line[i*WORD_BITS +: WORD_BITS];
    end

    // Word stage: the upper offset bits pick the word.
    assign word_sel = words[offset[OFF_W-1:BIDX_W]];

    for (genvar j = 0; j < WORD_BYTES; j++) begin : g_bytes
        assign bytes[j] = word_sel[j*8 +: 8];
    end

    // Byte stage: the lower offset bits pick the byte.
    assign byte_out = bytes[offset[BIDX_W-1:0]];

endmodule

// File: rtl/lkp_bank.sv
// Module: lkp_bank
// One independent bank. It holds the tag, valid and line arrays for its sets,
// plus one round-robin pointer per set. It compares every way of the looked-up
// set in parallel and drives the hitting line through a one-hot AND-OR select.
// A fill writes the victim way of the fill set.
// Assumes: lookup and fill never happen in the same cycle (the parent stalls
// requests while a fill is pending). Tag and line contents are not reset.
module lkp_bank #(
    parameter int WAYS      = 4,
    parameter int SETS      = 4,
    parameter int TAG_W     = 23,
    parameter int LINE_BITS = 256,
    localparam int SET_W    = $clog2(SETS),
    localparam int WAY_W    = $clog2(WAYS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SET_W-1:0]     look_set,
    input  logic [TAG_W-1:0]     look_tag,
    input  logic                 fill_en,
    input  logic [SET_W-1:0]     fill_set,
    input  logic [TAG_W-1:0]     fill_tag,
    input  logic [LINE_BITS-1:0] fill_line,
    output logic                 hit_any,
    output logic [LINE_BITS-1:0] hit_line
);

    logic [TAG_W-1:0]     tag_q  [SETS][WAYS];
    logic [LINE_BITS-1:0] line_q [SETS][WAYS];
    logic [WAYS-1:0]      vld_q  [SETS];
    logic [WAY_W-1:0]     rr_q   [SETS];
    logic [WAYS-1:0]      match;
    logic [WAY_W-1:0]     victim;
    logic                 all_valid;

    // Tag compare per way: valid bit AND an all-zero XOR of the tags.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = vld_q[look_set][w] &&
                          ~|(tag_q[look_set][w] ^ look_tag);
    end

    // Line stage: AND-OR over the one-hot match vector; zero when no way hits.
    always_comb begin
        hit_line = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_line = hit_line | (line_q[look_set][w] & {LINE_BITS{match[w]}});
        end
    end

    assign hit_any = |match;

    lkp_victim #(.WAYS(WAYS)) u_victim (
        .vld       (vld_q[fill_set]),
        .rr_ptr    (rr_q[fill_set]),
        .victim    (victim),
        .all_valid (all_valid)
    );

    // Tag and line storage: written by fills only, no reset.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_set][victim]  <= fill_tag;
            line_q[fill_set][victim] <= fill_line;
        end
    end

    // Valid bits and round-robin pointers: cleared on reset, updated on a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                rr_q[s]  <= '0;
            end
        end else if (fill_en) begin
            vld_q[fill_set][victim] <= 1'b1;
            if (all_valid) rr_q[fill_set] <= rr_q[fill_set] + 1'b1;
        end
    end

    // R8: no two ways of one set ever match the same lookup tag.
    assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R5: the way written by a fill is valid in the following cycle.
    assert_fill_sets_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> vld_q[$past(fill_set)][$past(victim)]);

    // R6: while some way is invalid, the fill does not land on a valid way.
    assert_victim_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !all_valid) |-> !vld_q[fill_set][victim]);

endmodule

// File: rtl/banked_cache_lookup.sv
// Module: banked_cache_lookup
// Top of the lookup unit. It decodes the address into offset, bank, set and
// tag, and runs the lookup in the bank that the bank index selects. The
// response is registered one cycle after acceptance. A miss makes the unit
// wait for a full-line fill, which is written to the bank and set of the
// missed line.
// Assumes: BANKS, SETS_PER_BANK, WAYS, LINE_BYTES are powers of two, each >= 2.
module banked_cache_lookup
    import cbl_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int WAYS          = 4,
    parameter int LINE_BYTES    = 32,
    parameter int WORD_BYTES    = 8,
    parameter int BANKS         = 4,
    parameter int SETS_PER_BANK = 4,
    localparam int OFF_W        = $clog2(LINE_BYTES),
    localparam int BANK_W       = $clog2(BANKS),
    localparam int SET_W        = $clog2(SETS_PER_BANK),
    localparam int TAG_W        = ADDR_W - OFF_W - BANK_W - SET_W,
    localparam int LINE_BITS    = LINE_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 req_ready,
    output logic                 resp_valid,
    output logic                 resp_hit,
    output logic                 resp_miss,
    output logic [7:0]           resp_data,
    output logic                 miss_valid,
    output logic [ADDR_W-1:0]    miss_addr,
    input  logic                 fill_valid,
    input  logic [LINE_BITS-1:0] fill_data
);

    localparam int BANK_LO = OFF_W;
    localparam int SET_LO  = OFF_W + BANK_W;
    localparam int TAG_LO  = OFF_W + BANK_W + SET_W;

    lkp_state_t          state_q;
    logic [ADDR_W-1:0]   miss_addr_q;
    logic                accept;
    logic                fill_fire;
    logic [OFF_W-1:0]    req_off;
    logic [BANK_W-1:0]   req_bank;
    logic [SET_W-1:0]    req_set;
    logic [TAG_W-1:0]    req_tag;
    logic [BANK_W-1:0]   fill_bank;
    logic [SET_W-1:0]    fill_set;
    logic [TAG_W-1:0]    fill_tag;
    logic [BANKS-1:0]    bank_hit;
    logic [LINE_BITS-1:0] bank_line [BANKS];
    logic                look_hit;
    logic [LINE_BITS-1:0] look_line;
    logic [7:0]          look_byte;
    logic                resp_valid_q, resp_hit_q, resp_miss_q;
    logic [7:0]          resp_data_q;

    // Field decode of the request and of the pending miss address.
    assign req_off   = req_addr[OFF_W-1:0];
    assign req_bank  = req_addr[SET_LO-1:BANK_LO];
    assign req_set   = req_addr[TAG_LO-1:SET_LO];
    assign req_tag   = req_addr[ADDR_W-1:TAG_LO];
    assign fill_bank = miss_addr_q[SET_LO-1:BANK_LO];
    assign fill_set  = miss_addr_q[TAG_LO-1:SET_LO];
    assign fill_tag  = miss_addr_q[ADDR_W-1:TAG_LO];

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign fill_fire = (state_q == ST_WAIT) && fill_valid;

    // One bank per bank index; only the addressed bank takes the fill.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        lkp_bank #(
            .WAYS      (WAYS),
            .SETS      (SETS_PER_BANK),
            .TAG_W     (TAG_W),
            .LINE_BITS (LINE_BITS)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .look_set  (req_set),
            .look_tag  (req_tag),
            .fill_en   (fill_fire && (fill_bank == BANK_W'(b))),
            .fill_set  (fill_set),
            .fill_tag  (fill_tag),
            .fill_line (fill_data),
            .hit_any   (bank_hit[b]),
            .hit_line  (bank_line[b])
        );
    end

    assign look_hit  = bank_hit[req_bank];
    assign look_line = bank_line[req_bank];

    lkp_byte_sel #(
        .LINE_BYTES (LINE_BYTES),
        .WORD_BYTES (WORD_BYTES)
    ) u_sel (
        .line     (look_line),
        .offset   (req_off),
        .byte_out (look_byte)
    );

    // Response register: one cycle after an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_q <= 1'b0;
            resp_hit_q   <= 1'b0;
            resp_miss_q  <= 1'b0;
            resp_data_q  <= '0;
        end else begin
            resp_valid_q <= accept;
            resp_hit_q   <= accept && look_hit;
            resp_miss_q  <= accept && !look_hit;
            resp_data_q  <= (accept && look_hit) ? look_byte : 8'h00;
        end
    end

    // Miss state machine: wait for a fill after a miss, then return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            miss_addr_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept && !look_hit) begin
                    state_q     <= ST_WAIT;
                    miss_addr_q <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                end
                ST_WAIT: if (fill_valid) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign resp_valid = resp_valid_q;
    assign resp_hit   = resp_hit_q;
    assign resp_miss  = resp_miss_q;
    assign resp_data  = resp_data_q;
    assign miss_valid = (state_q == ST_WAIT);
    assign miss_addr  = miss_addr_q;

    // R3: every accepted request is answered in the next cycle.
    assert_resp_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_valid);

    // R9: no response without an accepted request.
    assert_no_stray_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !resp_valid);

    // R3: a response is either a hit or a miss, never both or neither.
    assert_hit_xor_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_hit != resp_miss));

    // R4: a miss returns no data.
    assert_miss_data_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_miss) |-> (resp_data == 8'h00));

    // R4: a miss response comes with a pending line request.
    assert_miss_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_miss) |-> miss_valid);

    // R4: the line request address is line-aligned and requests are stalled.
    assert_miss_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> (miss_addr[OFF_W-1:0] == '0) && !req_ready);

    // R5: a taken fill releases the unit in the next cycle.
    assert_fill_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && fill_valid) |=> (req_ready && !miss_valid));

endmodule

// File: tb/banked_cache_lookup_tb.sv
`timescale 1ns/1ps
module banked_cache_lookup_tb;

    localparam int ADDR_W = 32;
    localparam int WAYS   = 4;
    localparam int LBYTES = 32;
    localparam int BANKS  = 4;
    localparam int SETS   = 4;
    localparam int LBITS  = LBYTES * 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready, resp_valid, resp_hit, resp_miss, miss_valid;
    logic [7:0]        resp_data;
    logic [ADDR_W-1:0] miss_addr;
    logic              fill_valid = 1'b0;
    logic [LBITS-1:0]  fill_data = '0;

    int n_checks = 0;
    int n_fails  = 0;

    // Reference model state
    logic [22:0]      m_tag  [BANKS][SETS][WAYS];
    bit               m_vld  [BANKS][SETS][WAYS];
    logic [LBITS-1:0] m_line [BANKS][SETS][WAYS];
    int               m_rr   [BANKS][SETS];

    always #2 clk = ~clk;

    banked_cache_lookup u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_miss(resp_miss),
        .resp_data(resp_data), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int tag, input int bank, input int set, input int off);
        return {tag[22:0], set[1:0], bank[1:0], off[4:0]};
    endfunction

    function automatic int model_find(input logic [31:0] a);
        int b = int'(a[6:5]);
        int s = int'(a[8:7]);
        for (int w = 0; w < WAYS; w++)
            if (m_vld[b][s][w] && m_tag[b][s][w] == a[31:9]) return w;
        return -1;
    endfunction

    task automatic model_fill(input logic [31:0] a, input logic [LBITS-1:0] ln);
        int b = int'(a[6:5]);
        int s = int'(a[8:7]);
        int v = -1;
        for (int w = WAYS - 1; w >= 0; w--) if (!m_vld[b][s][w]) v = w;
        if (v < 0) begin
            v = m_rr[b][s];
            m_rr[b][s] = (m_rr[b][s] + 1) % WAYS;
        end
        m_vld[b][s][v]  = 1'b1;
        m_tag[b][s][v]  = a[31:9];
        m_line[b][s][v] = ln;
    endtask

    function automatic logic [LBITS-1:0] rand_line();
        logic [LBITS-1:0] l;
        for (int i = 0; i < LBITS / 32; i++) l[i*32 +: 32] = $urandom();
        return l;
    endfunction

    // One request; on a miss optionally probes a stalled request, then fills.
    task automatic do_req(input logic [31:0] a, input string lbl, input bit stray);
        int w = model_find(a);
        logic [7:0] exp_b;
        logic [LBITS-1:0] ln;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(resp_valid == 1'b1, {lbl, " R3 resp_valid"}, resp_valid, 1);
        if (w >= 0) begin
            exp_b = m_line[a[6:5]][a[8:7]][w][a[4:0]*8 +: 8];
            check(resp_hit == 1'b1, {lbl, " hit"}, resp_hit, 1);
            check(resp_data == exp_b, {lbl, " R3 data"}, resp_data, exp_b);
        end else begin
            check(resp_miss == 1'b1, {lbl, " miss"}, resp_miss, 1);
            check(resp_data == 8'h00, {lbl, " R4 miss data"}, resp_data, 0);
            check(miss_valid && miss_addr == {a[31:5], 5'b0}, {lbl, " R4 miss_addr"},
                  miss_addr, {a[31:5], 5'b0});
            check(req_ready == 1'b0, {lbl, " R4 stall"}, req_ready, 0);
            if (stray) begin
                req_valid = 1'b1;
                req_addr  = a ^ 32'h0000_0200;
                @(negedge clk);
                req_valid = 1'b0;
                check(resp_valid == 1'b0, {lbl, " R9 no resp while stalled"}, resp_valid, 0);
                check(miss_valid == 1'b1, {lbl, " R9 miss kept"}, miss_valid, 1);
            end
            ln = rand_line();
            fill_valid = 1'b1;
            fill_data  = ln;
            @(negedge clk);
            fill_valid = 1'b0;
            check(req_ready == 1'b1 && miss_valid == 1'b0, {lbl, " R5 release"},
                  {req_ready, miss_valid}, 2);
            model_fill(a, ln);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        for (int b = 0; b < BANKS; b++)
            for (int s = 0; s < SETS; s++) begin
                m_rr[b][s] = 0;
                for (int w = 0; w < WAYS; w++) m_vld[b][s][w] = 1'b0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(resp_valid == 1'b0, "R1 resp_valid", resp_valid, 0);
        check(miss_valid == 1'b0, "R1 miss_valid", miss_valid, 0);

        // R1 first access misses; R3 offsets across words and bytes
        do_req(mk(5, 0, 0, 3), "R1 first", 1'b0);
        for (int o = 0; o < LBYTES; o += 5) do_req(mk(5, 0, 0, o), "R3 sweep", 1'b0);
        do_req(mk(5, 0, 0, 31), "R3 last byte", 1'b0);

        // R2: same tag and set in another bank is a separate line
        do_req(mk(5, 2, 0, 7), "R2 other bank", 1'b0);
        do_req(mk(5, 0, 0, 7), "R2 bank0 again", 1'b0);
        do_req(mk(5, 2, 0, 7), "R2 bank2 again", 1'b0);

        // R5: a fill with no miss pending is ignored
        @(negedge clk);
        fill_valid = 1'b1;
        fill_data  = '1;
        @(negedge clk);
        fill_valid = 1'b0;
        check(req_ready == 1'b1 && miss_valid == 1'b0, "R5 idle fill", miss_valid, 0);
        do_req(mk(5, 0, 0, 9), "R5 line unchanged", 1'b0);
        do_req(mk(9, 1, 3, 0), "R5 still miss", 1'b0);

        // R9: request while stalled
        do_req(mk(40, 3, 1, 2), "R9", 1'b1);

        // R6 / R7: fill a set, then replace round-robin
        for (int t = 10; t < 14; t++) do_req(mk(t, 1, 2, t), "R6 fill", 1'b0);
        for (int t = 10; t < 14; t++) do_req(mk(t, 1, 2, 1), "R6 all kept", 1'b0);
        do_req(mk(14, 1, 2, 4), "R7 evict way0", 1'b0);
        for (int t = 10; t < 15; t++) do_req(mk(t, 1, 2, 6), "R7 after evict", 1'b0);
        for (int t = 10; t < 15; t++) do_req(mk(t, 1, 2, 8), "R7 second round", 1'b0);

        // Constrained random mix, small tag pool for hits
        for (int i = 0; i < 400; i++) begin
            do_req(mk(int'($urandom_range(0, 6)), int'($urandom_range(0, 3)),
                      int'($urandom_range(0, 3)), int'($urandom_range(0, 31))),
                   "R3 random", ($urandom_range(0, 7) == 0));
        end
        finish_run();
    end

endmodule